// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary (pointing device) channel, and the single data port that a host reads. Each source raises a data-available level while it holds at least one byte and presents its oldest byte on a head bus. The arbiter keeps a registered copy of both levels and of the mode byte. From them it drives the buffer-full status flags, their copies in the output port, and one interrupt line per source. On a host read it returns one byte and pops the source it chose.

The keyboard channel always wins. The auxiliary channel is visible to the host only when it alone holds data. At that point the auxiliary-full flag rises, the auxiliary interrupt may fire, and a read takes its byte from the auxiliary head. All flags and interrupts are levels decoded from registered state, so each one follows its inputs exactly one clock later.

The selection is a three-state machine, `sel_e`:
- `SEL_NONE`: nothing pending.
- `SEL_KBD`: keyboard pending, with or without auxiliary data.
- `SEL_AUX`: auxiliary data pending alone.

Every clock the machine takes one of three transitions, from any state:
- `GO_NONE`: both levels are low.
- `GO_KBD`: the keyboard level is high.
- `GO_AUX`: only the auxiliary level is high.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset, obf, aux_obf, port_obf, port_aux_obf, kbd_irq and aux_irq are 0, rd_data is 0x00, and neither pop is asserted.
- R2: obf and port_obf go to 1 one clock after either kbd_avail or aux_avail is high. They go to 0 one clock after both are low.
- R3: aux_obf and port_aux_obf are 1 only when, one clock earlier, aux_avail was 1 and kbd_avail was 0.
- R4: When both sources are available, the keyboard wins: aux_obf and aux_irq stay 0, and a read pops and returns the keyboard head.
- R5: kbd_irq is 1 one clock after kbd_avail is 1 while mode bit 0 (keyboard interrupt enable) is 1 and mode bit 4 (keyboard disable) is 0. Otherwise it is 0.
- R6: aux_irq is 1 one clock after aux_avail is 1, kbd_avail is 0 and mode bit 1 (auxiliary interrupt enable) is 1. Otherwise it is 0.
- R7: In state SEL_AUX, a cycle with rd_strobe high asserts aux_pop in that cycle, and rd_data equals aux_head from the next clock on.
- R8: In state SEL_KBD, a cycle with rd_strobe high asserts kbd_pop in that cycle, and rd_data equals kbd_head from the next clock on.
- R9: In state SEL_NONE, rd_strobe pops neither source, and rd_data keeps its previous value.
- R10: A change of the mode byte alone, with no change in availability, moves the interrupts one clock later. The interrupts are never held as latched edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_avail | input | 1 | Keyboard source holds a byte |
| aux_avail | input | 1 | Auxiliary source holds a byte |
| mode_byte | input | 8 | Controller mode byte (bit 0 keyboard irq enable, bit 1 aux irq enable, bit 4 keyboard disable) |
| kbd_head | input | 8 | Oldest keyboard byte |
| aux_head | input | 8 | Oldest auxiliary byte |
| rd_strobe | input | 1 | Host reads the data port this cycle |
| obf | output | 1 | Status: output buffer full |
| aux_obf | output | 1 | Status: output buffer holds auxiliary data |
| port_obf | output | 1 | Output port copy of obf (port bit 4) |
| port_aux_obf | output | 1 | Output port copy of aux_obf (port bit 5) |
| kbd_irq | output | 1 | Keyboard interrupt level |
| aux_irq | output | 1 | Auxiliary interrupt level |
| rd_data | output | 8 | Byte returned by the last read |
| kbd_pop | output | 1 | Pop the keyboard source |
| aux_pop | output | 1 | Pop the auxiliary source |

## Verification
Flags and interrupts are due one clock after their inputs change. The bench drives inputs on the falling edge and checks on the next falling edge, after exactly one rising edge. The pops are combinational from the registered selection and the strobe, so they are checked just after the strobe is driven, before the rising edge. rd_data is checked on the falling edge that follows the capturing edge. Checks taken before the rising edge confirm that no output moves early, for example an interrupt that is still high just after its mode bit is cleared.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_KBD  = 2'b01,
        SEL_AUX  = 2'b10
    } sel_e;
endpackage

// File: rtl/obuf_sel_fsm.sv
module obuf_sel_fsm
    import obuf_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kbd_avail,
    input  logic aux_avail,
    output sel_e state
);
    sel_e state_q, state_d;

    // Transitions GO_NONE / GO_KBD / GO_AUX, taken from any state.
    always_comb begin
        unique case ({aux_avail, kbd_avail})
            2'b00:   state_d = SEL_NONE;
            2'b10:   state_d = SEL_AUX;
            2'b01,
            2'b11:   state_d = SEL_KBD;
            default: state_d = SEL_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_NONE;
        else        state_q <= state_d;
    end

    assign state = state_q;

    // R4
    sel_kbd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_avail |=> (state_q == SEL_KBD));
endmodule

// File: rtl/obuf_flag_dec.sv
module obuf_flag_dec
    import obuf_arb_pkg::*;
#(
    parameter int MODE_W       = 8,
    parameter int KBD_IRQ_BIT  = 0,
    parameter int AUX_IRQ_BIT  = 1,
    parameter int KBD_OFF_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sel_e              state,
    input  logic [MODE_W-1:0] mode_byte,
    output logic              obf,
    output logic              aux_obf,
    output logic              kbd_irq,
    output logic              aux_irq
);
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_byte;
    end

    always_comb begin
        obf     = 1'b0;
        aux_obf = 1'b0;
        kbd_irq = 1'b0;
        aux_irq = 1'b0;
        unique case (state)
            SEL_NONE: ;
            SEL_KBD: begin
                obf     = 1'b1;
                kbd_irq = mode_q[KBD_IRQ_BIT] & ~mode_q[KBD_OFF_BIT];
            end
            SEL_AUX: begin
                obf     = 1'b1;
                aux_obf = 1'b1;
                aux_irq = mode_q[AUX_IRQ_BIT];
            end
            default: ;
        endcase
    end

    logic unused_mode;
    assign unused_mode = ^mode_q;

    // R4
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_irq && aux_irq));

    // R5
    kbd_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_byte[KBD_OFF_BIT]) |-> !kbd_irq);
endmodule

// File: rtl/obuf_rd_port.sv
module obuf_rd_port
    import obuf_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sel_e              state,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] kbd_head,
    input  logic [DATA_W-1:0] aux_head,
    output logic              kbd_pop,
    output logic              aux_pop,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] data_q;

    always_comb begin
        kbd_pop = 1'b0;
        aux_pop = 1'b0;
        unique case (state)
            SEL_NONE: ;
            SEL_KBD:  kbd_pop = rd_strobe;
            SEL_AUX:  aux_pop = rd_strobe;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_strobe) begin
            unique case (state)
                SEL_NONE: data_q <= data_q;
                SEL_KBD:  data_q <= kbd_head;
                SEL_AUX:  data_q <= aux_head;
                default:  data_q <= data_q;
            endcase
        end
    end

    assign rd_data = data_q;

    // R7
    pops_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_pop, aux_pop}));

    // R9
    idle_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == SEL_NONE) |=> $stable(rd_data));
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
    import obuf_arb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int MODE_W      = 8,
    parameter int KBD_IRQ_BIT = 0,
    parameter int AUX_IRQ_BIT = 1,
    parameter int KBD_OFF_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_avail,
    input  logic              aux_avail,
    input  logic [MODE_W-1:0] mode_byte,
    input  logic [DATA_W-1:0] kbd_head,
    input  logic [DATA_W-1:0] aux_head,
    input  logic              rd_strobe,
    output logic              obf,
    output logic              aux_obf,
    output logic              port_obf,
    output logic              port_aux_obf,
    output logic              kbd_irq,
    output logic              aux_irq,
    output logic [DATA_W-1:0] rd_data,
    output logic              kbd_pop,
    output logic              aux_pop
);
    sel_e state;
    logic obf_w, aux_obf_w;

    obuf_sel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_avail (kbd_avail),
        .aux_avail (aux_avail),
        .state     (state)
    );

    obuf_flag_dec #(
        .MODE_W      (MODE_W),
        .KBD_IRQ_BIT (KBD_IRQ_BIT),
        .AUX_IRQ_BIT (AUX_IRQ_BIT),
        .KBD_OFF_BIT (KBD_OFF_BIT)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .mode_byte (mode_byte),
        .obf       (obf_w),
        .aux_obf   (aux_obf_w),
        .kbd_irq   (kbd_irq),
        .aux_irq   (aux_irq)
    );

    obuf_rd_port #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .rd_strobe (rd_strobe),
        .kbd_head  (kbd_head),
        .aux_head  (aux_head),
        .kbd_pop   (kbd_pop),
        .aux_pop   (aux_pop),
        .rd_data   (rd_data)
    );

    assign obf          = obf_w;
    assign aux_obf      = aux_obf_w;
    assign port_obf     = obf_w;
    assign port_aux_obf = aux_obf_w;

    // R2
    obf_follows_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_avail || aux_avail) |=> obf);

    // R3
    aux_only_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_avail && !kbd_avail) |=> aux_obf);

    // R3
    aux_flag_implies_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_obf |-> obf);
endmodule

// File: tb/obuf_arbiter_tb.sv
module obuf_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       kbd_avail, aux_avail, rd_strobe;
    logic [7:0] mode_byte, kbd_head, aux_head;
    logic       obf, aux_obf, port_obf, port_aux_obf, kbd_irq, aux_irq;
    logic [7:0] rd_data;
    logic       kbd_pop, aux_pop;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    obuf_arbiter u_dut (
        .clk (clk), .rst_n (rst_n),
        .kbd_avail (kbd_avail), .aux_avail (aux_avail),
        .mode_byte (mode_byte), .kbd_head (kbd_head), .aux_head (aux_head),
        .rd_strobe (rd_strobe),
        .obf (obf), .aux_obf (aux_obf),
        .port_obf (port_obf), .port_aux_obf (port_aux_obf),
        .kbd_irq (kbd_irq), .aux_irq (aux_irq),
        .rd_data (rd_data), .kbd_pop (kbd_pop), .aux_pop (aux_pop)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic flags(input string req, input logic o, input logic a);
        chk(req, {7'd0, obf}, {7'd0, o});
        chk(req, {7'd0, port_obf}, {7'd0, o});
        chk(req, {7'd0, aux_obf}, {7'd0, a});
        chk(req, {7'd0, port_aux_obf}, {7'd0, a});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; kbd_avail = 0; aux_avail = 0; rd_strobe = 0;
        mode_byte = 8'h03; kbd_head = 8'h1C; aux_head = 8'h08;
        step(); step();
        rst_n = 1'b1;
        #1;
        flags("R1", 1'b0, 1'b0);
        chk("R1 kbd_irq", {7'd0, kbd_irq}, 8'd0);
        chk("R1 aux_irq", {7'd0, aux_irq}, 8'd0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 pops", {6'd0, kbd_pop, aux_pop}, 8'd0);
    endtask

    task automatic t_flags();
        step();
        kbd_avail = 1; #1;
        chk("R2 no early obf", {7'd0, obf}, 8'd0);
        step();
        flags("R2 kbd only", 1'b1, 1'b0);
        kbd_avail = 0; aux_avail = 1;
        step();
        flags("R3 aux only", 1'b1, 1'b1);
        kbd_avail = 1;
        step();
        flags("R4 both pending", 1'b1, 1'b0);
        kbd_avail = 0; aux_avail = 0;
        step();
        flags("R2 none pending", 1'b0, 1'b0);
    endtask

    task automatic t_irq();
        kbd_avail = 1; mode_byte = 8'h01;
        step();
        chk("R5 kbd irq enabled", {7'd0, kbd_irq}, 8'd1);
        mode_byte = 8'h00; #1;
        chk("R10 irq holds until edge", {7'd0, kbd_irq}, 8'd1);
        step();
        chk("R10 irq drops on mode change", {7'd0, kbd_irq}, 8'd0);
        mode_byte = 8'h11;
        step();
        chk("R5 kbd disabled gates irq", {7'd0, kbd_irq}, 8'd0);
        mode_byte = 8'h01;
        step();
        chk("R10 irq returns as level", {7'd0, kbd_irq}, 8'd1);
        kbd_avail = 0; aux_avail = 1; mode_byte = 8'h02;
        step();
        chk("R6 aux irq", {7'd0, aux_irq}, 8'd1);
        chk("R6 kbd irq low", {7'd0, kbd_irq}, 8'd0);
        mode_byte = 8'h01;
        step();
        chk("R6 aux irq disabled", {7'd0, aux_irq}, 8'd0);
        kbd_avail = 1; mode_byte = 8'h03;
        step();
        chk("R4 aux irq suppressed", {7'd0, aux_irq}, 8'd0);
        chk("R4 kbd irq", {7'd0, kbd_irq}, 8'd1);
        kbd_avail = 0; aux_avail = 0;
        step();
        chk("R5 irq off when empty", {6'd0, kbd_irq, aux_irq}, 8'd0);
    endtask

    task automatic t_reads();
        aux_avail = 1; aux_head = 8'h5A; kbd_head = 8'hC3;
        step();
        rd_strobe = 1; #1;
        chk("R7 aux pop", {6'd0, kbd_pop, aux_pop}, 8'b01);
        step();
        rd_strobe = 0;
        chk("R7 aux byte", rd_data, 8'h5A);
        kbd_avail = 1;
        step();
        rd_strobe = 1; #1;
        chk("R4 kbd pop when both", {6'd0, kbd_pop, aux_pop}, 8'b10);
        step();
        rd_strobe = 0;
        chk("R4 kbd byte when both", rd_data, 8'hC3);
        aux_avail = 0; kbd_head = 8'h9E;
        step();
        rd_strobe = 1; #1;
        chk("R8 kbd pop", {6'd0, kbd_pop, aux_pop}, 8'b10);
        step();
        rd_strobe = 0;
        chk("R8 kbd byte", rd_data, 8'h9E);
        kbd_avail = 0; kbd_head = 8'h11; aux_head = 8'h22;
        step();
        rd_strobe = 1; #1;
        chk("R9 no pop when empty", {6'd0, kbd_pop, aux_pop}, 8'b00);
        step();
        rd_strobe = 0;
        chk("R9 data held", rd_data, 8'h9E);
    endtask

    initial begin
        t_reset();
        t_flags();
        t_irq();
        t_reads();
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule